// File: doc/BRIEF.md
# Serial Elastic Buffer with Slip Fault

This block carries a one-bit-wide serial stream from a recovered receive clock into a local transmit clock for a loopback path. Each frame is a contiguous run of cycles with `in_valid` high on the write clock. Every accepted bit goes into a ten-entry ring together with a flag that marks the final bit of its frame. The write count crosses to the read clock as gray code through a two-flop synchronizer, and a one-bit "frame in progress" indication crosses beside it. At every frame start the read side holds off until half the ring has been filled, which recentres the buffer. It then offers one bit per cycle on a valid/ready output.

A slip fault ends the frame that caused it. There are two kinds. An over-run is seen when more than ten unread bits are outstanding, which means the writer has lapped the reader. An under-run is seen when the consumer pulls while the ring is empty in the middle of a frame. When a fault is seen, `out_valid` drops in that same cycle and `out_abort` pulses once. The rest of the frame is discarded without any last marker, and a sticky `slip_fault` bit is set for a status register. A status-read strobe clears that bit.

Back-pressure rules: the source side has no back-pressure. `in_ready` is high whenever the write domain is out of reset, and every bit presented with `in_valid` is taken. On the output side a bit transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low the offered bit is held. Sustained back-pressure fills the ring and ends in an over-run. Frames must be separated by at least four cycles of the slower clock with `in_valid` low.

Top module: `serial_elastic_buf`

## Requirements
- R1: The ring holds DEPTH = 10 entries. `in_ready` is low while `wr_rst_n` is asserted and high otherwise, and every bit presented with `in_valid` high while `in_ready` is high is stored.
- R2: After a frame starts, `out_valid` stays low until the read side sees at least DEPTH/2 = 5 stored bits. A frame shorter than that is released only after its writer side has gone idle, and it is released whole.
- R3: Bits leave in arrival order, one per cycle with `out_valid` and `out_ready` both high. `out_last` is 1 on the final bit of a frame only. Bits still buffered when `in_valid` falls are drained before the frame closes.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged into the next cycle unless the frame is terminated.
- R5: An over-run (more than 10 unread bits) terminates the frame. `out_valid` is low from the detection cycle, `out_abort` is a one-cycle pulse during which `out_valid` is low, and no bit of that frame is delivered with `out_last` = 1.
- R6: An under-run (`out_ready` high while the ring is empty inside a frame) terminates the frame in the same way as R5.
- R7: `slip_fault` resets to 0 and is 1 in every cycle in which `out_abort` is 1. It stays 1 until a cycle with `sts_rd` high, and it reads 0 in the following cycle unless a new fault arrives in that same cycle.
- R8: After a terminated frame, the next frame is prefilled afresh and delivered intact, with its bits in order and its last marker present.
- R9: After reset, `out_valid`, `out_abort` and `slip_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| in_valid | input | 1 | Bit present; a high run forms one frame |
| in_data | input | 1 | Serial data bit |
| in_ready | output | 1 | High outside write reset; no back-pressure |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Consumer takes the offered bit |
| out_data | output | 1 | Output serial bit |
| out_last | output | 1 | Offered bit ends its frame |
| out_abort | output | 1 | One-cycle pulse when a frame is terminated |
| sts_rd | input | 1 | Status-read strobe that clears the fault bit |
| slip_fault | output | 1 | Sticky over-run/under-run flag |

## Verification
The bench aims at the gap between the two sides of the ring. It stalls the consumer briefly, which must not fault, and stalls it long enough that the writer laps the reader. A design that ignores the lap would deliver overwritten bits, or a frame with a last marker, where an abort is required. A slower write clock forces an under-run. A design that waits on an empty ring would stretch the frame instead of ending it, and a design that does not drop valid would hand out stale entries. Short frames of one and four bits check that release does not wait forever for a half-full ring. A clean frame after each fault checks that leftover pointers or discard state do not eat or shift the next frame.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef struct packed {
    logic last;
    logic data;
  } esb_entry_t;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_RUN  = 2'd1,
    RD_DROP = 2'd2
  } esb_rd_state_t;

endpackage

// File: rtl/esb_cnt_sync.sv
module esb_cnt_sync #(
  parameter int W = 6
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);

  logic [W-1:0] gray_q;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    dst_bin[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      dst_bin[i] = dst_bin[i+1] ^ sync_q[i];
    end
  end

endmodule

// File: rtl/esb_ring.sv
module esb_ring
  import esb_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  esb_entry_t    wentry,
  input  logic [IW-1:0] ridx,
  output esb_entry_t    rentry
);

  esb_entry_t slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wentry;
  end

  assign rentry = slot_q[ridx];

endmodule

// File: rtl/esb_wr_ctrl.sv
module esb_wr_ctrl
  import esb_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_data,
  output logic          in_ready,
  output logic          we,
  output logic [IW-1:0] widx,
  output esb_entry_t    wentry,
  output logic [CW-1:0] wcnt,
  output logic          busy
);

  logic rdy_q;
  logic hold_vld;
  logic hold_bit;
  logic take;

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  // The held bit is written once the next cycle shows whether it was the last.
  assign we          = hold_vld;
  assign wentry.data = hold_bit;
  assign wentry.last = !take;
  assign busy        = hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      hold_vld <= 1'b0;
      hold_bit <= 1'b0;
      widx     <= '0;
      wcnt     <= '0;
    end else begin
      rdy_q    <= 1'b1;
      hold_vld <= take;
      if (take) hold_bit <= in_data;
      if (we) begin
        widx <= (widx == IW'(DEPTH - 1)) ? '0 : widx + 1'b1;
        wcnt <= wcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl
  import esb_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 2,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] wcnt_s,
  input  logic          busy_s,
  input  esb_entry_t    rentry,
  output logic [IW-1:0] ridx,
  output logic [CW-1:0] fill,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_data,
  output logic          out_last,
  output logic          out_abort,
  input  logic          sts_rd,
  output logic          slip_fault
);

  esb_rd_state_t state_q, state_d;
  logic [CW-1:0] rcnt;
  logic          avail;
  logic          lapped;
  logic          start;
  logic          adv;
  logic          fault_evt;
  logic          abort_q;
  logic          fault_q;

  assign fill   = wcnt_s - rcnt;
  assign avail  = (fill != '0);
  assign lapped = (fill > CW'(DEPTH));
  assign start  = (fill >= CW'(HALF)) || (avail && !busy_s);

  always_comb begin
    state_d   = state_q;
    adv       = 1'b0;
    fault_evt = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (lapped) begin
          fault_evt = 1'b1;
          state_d   = RD_DROP;
        end else if (start) begin
          state_d = RD_RUN;
        end
      end
      RD_RUN: begin
        if (lapped) begin
          fault_evt = 1'b1;
          state_d   = RD_DROP;
        end else if (avail) begin
          if (out_ready) begin
            adv = 1'b1;
            if (rentry.last) state_d = RD_IDLE;
          end
        end else if (out_ready) begin
          fault_evt = 1'b1;
          state_d   = RD_DROP;
        end
      end
      RD_DROP: begin
        if (avail)        adv     = 1'b1;
        else if (!busy_s) state_d = RD_IDLE;
      end
      default: state_d = RD_IDLE;
    endcase
  end

  assign out_valid  = (state_q == RD_RUN) && avail && !lapped;
  assign out_data   = rentry.data;
  assign out_last   = rentry.last;
  assign out_abort  = abort_q;
  assign slip_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      rcnt    <= '0;
      ridx    <= '0;
      abort_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= fault_evt;
      fault_q <= fault_evt || (fault_q && !sts_rd);
      if (adv) begin
        rcnt <= rcnt + 1'b1;
        ridx <= (ridx == IW'(DEPTH - 1)) ? '0 : ridx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_elastic_buf.sv
module serial_elastic_buf
  import esb_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic in_valid,
  input  logic in_data,
  output logic in_ready,
  input  logic rd_clk,
  input  logic rd_rst_n,
  output logic out_valid,
  input  logic out_ready,
  output logic out_data,
  output logic out_last,
  output logic out_abort,
  input  logic sts_rd,
  output logic slip_fault
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH) + 2;

  logic          we;
  logic [IW-1:0] widx;
  logic [IW-1:0] ridx;
  esb_entry_t    wentry;
  esb_entry_t    rentry;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] wcnt_s;
  logic [CW-1:0] rd_fill;
  logic          busy;
  logic          busy_s;

  esb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .we       (we),
    .widx     (widx),
    .wentry   (wentry),
    .wcnt     (wcnt),
    .busy     (busy)
  );

  esb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk    (wr_clk),
    .we     (we),
    .widx   (widx),
    .wentry (wentry),
    .ridx   (ridx),
    .rentry (rentry)
  );

  esb_cnt_sync #(.W(CW)) u_cnt_sync (
    .src_clk   (wr_clk),
    .src_rst_n (wr_rst_n),
    .src_bin   (wcnt),
    .dst_clk   (rd_clk),
    .dst_rst_n (rd_rst_n),
    .dst_bin   (wcnt_s)
  );

  esb_cnt_sync #(.W(1)) u_busy_sync (
    .src_clk   (wr_clk),
    .src_rst_n (wr_rst_n),
    .src_bin   (busy),
    .dst_clk   (rd_clk),
    .dst_rst_n (rd_rst_n),
    .dst_bin   (busy_s)
  );

  esb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .wcnt_s     (wcnt_s),
    .busy_s     (busy_s),
    .rentry     (rentry),
    .ridx       (ridx),
    .fill       (rd_fill),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_abort  (out_abort),
    .sts_rd     (sts_rd),
    .slip_fault (slip_fault)
  );

endmodule

// File: rtl/esb_chk.sv
module esb_chk #(
  parameter int DEPTH = 10
) (
  input logic                       rd_clk,
  input logic                       rd_rst_n,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic                       out_data,
  input logic                       out_last,
  input logic                       out_abort,
  input logic                       sts_rd,
  input logic                       slip_fault,
  input logic [$clog2(DEPTH)+1:0]   rd_fill
);

  localparam int CW = $clog2(DEPTH) + 2;

  AST_ABORT_SETS_FAULT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_abort |-> slip_fault); // R7

  AST_ABORT_NO_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_abort |-> !out_valid); // R5

  AST_FAULT_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (slip_fault && !sts_rd) |=> slip_fault); // R7

  AST_FAULT_CLEAR: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    sts_rd |=> (!slip_fault || out_abort)); // R7

  AST_OFFER_HELD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (out_valid && !out_ready) |=>
      ((out_valid && $stable(out_data) && $stable(out_last)) || (rd_fill > CW'(DEPTH)))); // R4

  AST_LAPPED_NO_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_fill > CW'(DEPTH)) |-> !out_valid); // R5

endmodule

bind serial_elastic_buf esb_chk #(.DEPTH(DEPTH)) u_esb_chk (.*);

// File: tb/test_serial_elastic_buf.sv
module test_serial_elastic_buf;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_rst_n, rd_rst_n;
  logic in_valid, in_data, in_ready;
  logic out_valid, out_ready, out_data, out_last, out_abort;
  logic sts_rd, slip_fault;

  real wr_half = 10.1;
  always #(wr_half) wr_clk = ~wr_clk;
  always #10 rd_clk = ~rd_clk;

  serial_elastic_buf i_serial_elastic_buf (.*);

  int checks = 0;
  int fails  = 0;

  // Vector: [63:56] len, [55:48] stall start, [47:40] stall length,
  // [39:32] flags (bit0 expect fault, bit1 clear fault after), [31:0] pattern
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {8'd16, 8'd0, 8'd0,  8'h00, 32'hA5C3_0F96},  // R3 R2
    {8'd1,  8'd0, 8'd0,  8'h00, 32'h0000_0001},  // R2 short
    {8'd4,  8'd0, 8'd0,  8'h00, 32'h0000_000B},  // R2 short
    {8'd32, 8'd5, 8'd1,  8'h00, 32'hDEAD_BEEF},  // R4 brief stall
    {8'd24, 8'd4, 8'd12, 8'h01, 32'h00C3_5A3C},  // R5 over-run
    {8'd20, 8'd0, 8'd0,  8'h02, 32'h0006_9D2B}   // R8 clean after fault
  };

  // collector state
  logic got_d [64];
  logic got_l [64];
  int   gcnt, n_last, aborts, abort_viol, start_sent;
  bit   seen_v;
  int   wr_sent;
  bit   exp_sticky;

  always @(negedge rd_clk) begin
    if (out_valid && !seen_v) begin
      seen_v     = 1'b1;
      start_sent = wr_sent;
    end
    if (out_valid && out_ready && gcnt < 64) begin
      got_d[gcnt] = out_data;
      got_l[gcnt] = out_last;
      if (out_last) n_last++;
      gcnt++;
    end
    if (out_abort) begin
      aborts++;
      if (out_valid) abort_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_collector();
    @(posedge rd_clk); #1;
    gcnt = 0; n_last = 0; aborts = 0; abort_viol = 0;
    seen_v = 1'b0; start_sent = 0; wr_sent = 0;
  endtask

  task automatic send_frame(input int len, input logic [31:0] pat);
    for (int i = 0; i < len; i++) begin
      @(negedge wr_clk);
      in_valid = 1'b1;
      in_data  = pat[i % 32];
      wr_sent++;
    end
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  task automatic stall_ready(input int at, input int n);
    if (n > 0) begin
      wait (seen_v);
      repeat (at) @(posedge rd_clk);
      #2 out_ready = 1'b0;
      repeat (n) @(posedge rd_clk);
      #2 out_ready = 1'b1;
    end
  endtask

  task automatic pulse_sts();
    @(posedge rd_clk); #2 sts_rd = 1'b1;
    @(posedge rd_clk); #2 sts_rd = 1'b0;
  endtask

  task automatic check_frame(input int len, input logic [31:0] pat,
                             input bit expf, input string req);
    int mism = 0;
    for (int i = 0; i < gcnt; i++)
      if (got_d[i] !== pat[i % 32]) mism++;
    chk(mism == 0, req, "bit order mismatches", mism, 0);
    if (expf) begin
      chk(aborts == 1, req, "abort pulses", aborts, 1);
      chk(n_last == 0, req, "last markers on terminated frame", n_last, 0);
      chk(abort_viol == 0, req, "valid during abort", abort_viol, 0);
    end else begin
      chk(aborts == 0, req, "abort pulses", aborts, 0);
      chk(gcnt == len, "R3", "bits delivered", gcnt, len);
      chk(n_last == 1 && got_l[len-1] === 1'b1, "R3", "last on final bit", n_last, 1);
      if (len >= 6)
        chk(start_sent >= 6, "R2", "bits sent before first valid", start_sent, 6);
      else
        chk(start_sent == len, "R2", "short frame released whole", start_sent, len);
    end
  endtask

  initial begin
    repeat (150000) @(posedge rd_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    in_valid = 1'b0; in_data = 1'b0;
    out_ready = 1'b1; sts_rd = 1'b0;
    exp_sticky = 1'b0;
    gcnt = 0; n_last = 0; aborts = 0; abort_viol = 0;
    seen_v = 1'b0; start_sent = 0; wr_sent = 0;

    repeat (5) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_abort == 1'b0, "R9", "out_abort after reset", out_abort, 0);
    chk(slip_fault == 1'b0, "R9", "slip_fault after reset", slip_fault, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    for (int v = 0; v < NV; v++) begin
      int len      = int'(VEC[v][63:56]);
      int st_at    = int'(VEC[v][55:48]);
      int st_len   = int'(VEC[v][47:40]);
      bit expf     = VEC[v][32];
      bit clr      = VEC[v][33];
      logic [31:0] pat = VEC[v][31:0];
      clear_collector();
      fork
        send_frame(len, pat);
        stall_ready(st_at, st_len);
      join
      repeat (40) @(posedge rd_clk);
      @(negedge rd_clk);
      check_frame(len, pat, expf, expf ? "R5" : (v == 5 ? "R8" : "R3"));
      if (expf) exp_sticky = 1'b1;
      chk(slip_fault == exp_sticky, "R7", "sticky fault level", slip_fault, exp_sticky);
      if (clr) begin
        pulse_sts();
        @(negedge rd_clk);
        exp_sticky = 1'b0;
        chk(slip_fault == 1'b0, "R7", "fault after status read", slip_fault, 0);
      end
    end

    // R6: slower write clock drains the ring mid-frame
    wr_half = 15.0;
    repeat (10) @(posedge rd_clk);
    clear_collector();
    send_frame(40, 32'h5F0A_C396);
    repeat (40) @(posedge rd_clk);
    @(negedge rd_clk);
    check_frame(40, 32'h5F0A_C396, 1'b1, "R6");
    chk(slip_fault == 1'b1, "R6", "fault after under-run", slip_fault, 1);

    // R8: nominal clock again, frame must pass intact
    wr_half = 10.1;
    repeat (10) @(posedge rd_clk);
    clear_collector();
    send_frame(28, 32'h0B7E_1365);
    repeat (40) @(posedge rd_clk);
    @(negedge rd_clk);
    check_frame(28, 32'h0B7E_1365, 1'b0, "R8");
    chk(slip_fault == 1'b1, "R7", "fault still held before read", slip_fault, 1);
    pulse_sts();
    @(negedge rd_clk);
    chk(slip_fault == 1'b0, "R7", "fault cleared by status read", slip_fault, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule